// File: doc/BRIEF.md
# Request-Triggered Four-Channel Transfer Engine

This block moves data between memory locations on behalf of peripherals without software involvement per item. Each of its four channels holds a source address, a destination address, a remaining-unit count and a control field selecting unit size and address stepping. A one-cycle pulse on a channel's request line, raised the way a peripheral raises an interrupt, moves exactly one unit: the engine asks for the memory bus, holds the processor, reads one unit from the source, writes it to the destination on the next cycle, steps the addresses and releases the bus.

Software programs the channels through a small write-only register port. A channel is armed whenever its count is nonzero. When the last unit of a channel has been moved, that channel raises a one-cycle completion pulse and stops accepting requests until its count is written again. When requests from several channels are waiting, the lowest channel number is served first and the rest stay pending.

The memory port is a single-cycle 32-bit port with byte enables; read data returns on the cycle after the read is issued. Addresses are byte addresses, and unit addresses are expected to be aligned to the unit size.

Top module: `irq_dma_ctrl`

## Requirements
- R1: Each of the four channels keeps its own source, destination, count and control values; a write with `reg_we` high updates the field picked by `reg_sel` (0 source, 1 destination, 2 count, 3 control) of channel `reg_ch` only.
- R2: A one-cycle pulse on `dma_req[n]` for an armed channel produces exactly one read at the channel's source address followed on the very next cycle by one write at its destination address.
- R3: Control bits [1:0] select the unit size: 0 byte, 1 16-bit, 2 32-bit; byte enables cover the unit's lanes starting at address bits [1:0], and the data read from the source lanes lands in the destination lanes.
- R4: Control bits [3:2] select stepping after each unit: 0 source steps and destination stays, 1 source stays and destination steps, 2 both step, 3 neither steps; the step is 1, 2 or 4 bytes to match the unit size.
- R5: The count drops by one per unit; the unit that brings it to zero pulses `done_irq[n]` high for one cycle, in the cycle in which `cpu_hold` has just dropped, and no other unit raises it.
- R6: A request to a channel whose count is zero is ignored: no bus request, no hold and no memory access follow.
- R7: When several armed channels have requests waiting, the lowest-numbered one is served first and the others are served afterwards without a new request.
- R8: `bus_req` is raised before any memory access and the engine issues no access while `bus_grant` is low; it waits as long as the grant stays low.
- R9: `cpu_hold` is high from the cycle after a request is taken until the write of that unit has completed, covering the wait for the grant and both accesses.
- R10: After reset all counts are zero, nothing is pending and `cpu_hold`, `bus_req`, `mem_en` and `done_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel addressed by the write |
| reg_sel | input | 2 | Field: 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | 32 | Write data |
| dma_req | input | 4 | Per-channel transfer request pulses |
| done_irq | output | 4 | Per-channel completion pulses |
| bus_req | output | 1 | Request for the memory bus |
| bus_grant | input | 1 | Memory bus granted to the engine |
| cpu_hold | output | 1 | Processor execution suspended |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 24 | Byte address of the access |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The assertions take for granted that the grant, once given, stays high while `bus_req` is high, that read data comes back one cycle after the read, and that unit addresses are aligned to their size so the lane enables stay inside one word. The bench grants the bus from a register that follows `bus_req`, models a memory that answers reads one cycle later, and programs only aligned addresses. Requests are single-cycle pulses issued between transfers, except in the priority scenario, where two arrive in the same cycle on purpose.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;

   localparam logic [1:0] FLD_SRC  = 2'd0;
   localparam logic [1:0] FLD_DST  = 2'd1;
   localparam logic [1:0] FLD_CNT  = 2'd2;
   localparam logic [1:0] FLD_CTRL = 2'd3;

   localparam logic [1:0] UNIT_B8  = 2'd0;
   localparam logic [1:0] UNIT_B16 = 2'd1;

   localparam logic [1:0] STEP_SRC  = 2'd0;
   localparam logic [1:0] STEP_DST  = 2'd1;
   localparam logic [1:0] STEP_BOTH = 2'd2;

   typedef enum logic [1:0] {
      XS_IDLE,
      XS_WAIT,
      XS_READ,
      XS_WRITE
   } xfer_state_t;

   function automatic logic [2:0] unit_bytes(input logic [1:0] unit);
      case (unit)
         UNIT_B8:  return 3'd1;
         UNIT_B16: return 3'd2;
         default:  return 3'd4;
      endcase
   endfunction

   function automatic logic [3:0] unit_lanes(input logic [1:0] unit, input logic [1:0] lo);
      logic [3:0] base;
      case (unit)
         UNIT_B8:  base = 4'b0001;
         UNIT_B16: base = 4'b0011;
         default:  base = 4'b1111;
      endcase
      return base << lo;
   endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import irq_dma_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_fld,
   input  logic [31:0]       wr_data,
   input  logic              step_en,
   output logic [ADDR_W-1:0] src_q,
   output logic [ADDR_W-1:0] dst_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [1:0]        unit_q,
   output logic [1:0]        mode_q
);

   logic [ADDR_W-1:0] step;
   logic              src_moves;
   logic              dst_moves;

   assign step      = ADDR_W'(unit_bytes(unit_q));
   assign src_moves = (mode_q == STEP_SRC) || (mode_q == STEP_BOTH);
   assign dst_moves = (mode_q == STEP_DST) || (mode_q == STEP_BOTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         unit_q <= UNIT_B8;
         mode_q <= STEP_SRC;
      end else if (step_en) begin
         if (src_moves) src_q <= src_q + step;
         if (dst_moves) dst_q <= dst_q + step;
         cnt_q <= cnt_q - 1'b1;
      end else if (wr_en) begin
         case (wr_fld)
            FLD_SRC:  src_q <= wr_data[ADDR_W-1:0];
            FLD_DST:  dst_q <= wr_data[ADDR_W-1:0];
            FLD_CNT:  cnt_q <= wr_data[CNT_W-1:0];
            default: begin
               unit_q <= wr_data[1:0];
               mode_q <= wr_data[3:2];
            end
         endcase
      end
   end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
   parameter int N     = 4,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     pend,
   output logic             any,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     onehot
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) idx = IDX_W'(i);
      end
      any    = |pend;
      onehot = any ? (N'(1) << idx) : '0;
   end

endmodule

// File: rtl/dma_lane_steer.sv
module dma_lane_steer #(
   parameter int DATA_W = 32,
   parameter int LO_W   = $clog2(DATA_W / 8)
) (
   input  logic [DATA_W-1:0] rd_data,
   input  logic [LO_W-1:0]   src_lo,
   input  logic [LO_W-1:0]   dst_lo,
   output logic [DATA_W-1:0] wr_data
);

   logic [DATA_W-1:0] aligned;

   assign aligned = rd_data >> {src_lo, 3'b000};
   assign wr_data = aligned << {dst_lo, 3'b000};

endmodule

// File: rtl/irq_dma_ctrl.sv
module irq_dma_ctrl
   import irq_dma_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 16,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [CH_W-1:0]   reg_ch,
   input  logic [1:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   input  logic [NUM_CH-1:0] dma_req,
   output logic [NUM_CH-1:0] done_irq,
   output logic              bus_req,
   input  logic              bus_grant,
   output logic              cpu_hold,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata
);

   localparam int DATA_W = 32;

   if (NUM_CH != 4) begin : g_bad_ch
      $error("irq_dma_ctrl: NUM_CH must be 4");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("irq_dma_ctrl: ADDR_W must lie in 8..32");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("irq_dma_ctrl: CNT_W must lie in 1..32");
   end

   logic [ADDR_W-1:0] src_a  [NUM_CH];
   logic [ADDR_W-1:0] dst_a  [NUM_CH];
   logic [CNT_W-1:0]  cnt_a  [NUM_CH];
   logic [1:0]        unit_a [NUM_CH];
   logic [1:0]        mode_a [NUM_CH];
   logic [NUM_CH-1:0] armed;
   logic [NUM_CH-1:0] last_unit;
   logic [NUM_CH-1:0] step_vec;

   xfer_state_t       state_q;
   logic [CH_W-1:0]   cur_q;
   logic [NUM_CH-1:0] pend_q;
   logic [NUM_CH-1:0] eligible;
   logic [NUM_CH-1:0] take_vec;
   logic [CH_W-1:0]   win_idx;
   logic              win_any;
   logic              take;

   assign step_vec = (state_q == XS_WRITE) ? (NUM_CH'(1) << cur_q) : '0;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      dma_chan_regs #(
         .ADDR_W (ADDR_W),
         .CNT_W  (CNT_W)
      ) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_we && (reg_ch == CH_W'(c))),
         .wr_fld  (reg_sel),
         .wr_data (reg_wdata),
         .step_en (step_vec[c]),
         .src_q   (src_a[c]),
         .dst_q   (dst_a[c]),
         .cnt_q   (cnt_a[c]),
         .unit_q  (unit_a[c]),
         .mode_q  (mode_a[c])
      );
      assign armed[c]     = (cnt_a[c] != '0);
      assign last_unit[c] = (cnt_a[c] == CNT_W'(1));
   end

   assign eligible = pend_q & armed;

   dma_prio_arb #(
      .N     (NUM_CH),
      .IDX_W (CH_W)
   ) u_arb (
      .pend   (eligible),
      .any    (win_any),
      .idx    (win_idx),
      .onehot (take_vec)
   );

   assign take = (state_q == XS_IDLE) && win_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         pend_q <= ((pend_q & ~(take ? take_vec : '0)) | dma_req) & armed;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= XS_IDLE;
         cur_q    <= '0;
         done_irq <= '0;
      end else begin
         done_irq <= '0;
         case (state_q)
            XS_IDLE: begin
               if (win_any) begin
                  cur_q   <= win_idx;
                  state_q <= XS_WAIT;
               end
            end
            XS_WAIT: begin
               if (bus_grant) state_q <= XS_READ;
            end
            XS_READ: state_q <= XS_WRITE;
            default: begin
               if (last_unit[cur_q]) done_irq <= NUM_CH'(1) << cur_q;
               state_q <= XS_IDLE;
            end
         endcase
      end
   end

   logic [ADDR_W-1:0] cur_src;
   logic [ADDR_W-1:0] cur_dst;
   logic [1:0]        cur_unit;
   logic [DATA_W-1:0] steered;

   assign cur_src  = src_a[cur_q];
   assign cur_dst  = dst_a[cur_q];
   assign cur_unit = unit_a[cur_q];

   dma_lane_steer #(
      .DATA_W (DATA_W)
   ) u_steer (
      .rd_data (mem_rdata),
      .src_lo  (cur_src[1:0]),
      .dst_lo  (cur_dst[1:0]),
      .wr_data (steered)
   );

   assign cpu_hold = (state_q != XS_IDLE);
   assign bus_req  = (state_q != XS_IDLE);

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_be    = '0;
      mem_wdata = '0;
      case (state_q)
         XS_READ: begin
            mem_en   = 1'b1;
            mem_addr = cur_src;
            mem_be   = unit_lanes(cur_unit, cur_src[1:0]);
         end
         XS_WRITE: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_dst;
            mem_be    = unit_lanes(cur_unit, cur_dst[1:0]);
            mem_wdata = steered;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/irq_dma_ctrl_chk.sv
module irq_dma_ctrl_chk #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] done_irq,
   input logic              bus_req,
   input logic              bus_grant,
   input logic              cpu_hold,
   input logic              mem_en,
   input logic              mem_we,
   input logic [3:0]        mem_be
);

   // R2: a read is always followed at once by the write of the same unit
   p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we) |=> (mem_en && mem_we));

   // R2: no write without the read one cycle before
   p_read_before_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> $past(mem_en && !mem_we));

   // R3: lane enables span exactly one unit size
   p_unit_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

   // R5: at most one completion at a time
   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done_irq));

   // R5: completion coincides with the release of the processor
   p_done_at_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|done_irq) |-> $fell(cpu_hold));

   // R8: accesses only under a held grant
   p_access_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (bus_grant && bus_req));

   // R9: processor is held across every access
   p_hold_covers_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> cpu_hold);

endmodule

bind irq_dma_ctrl irq_dma_ctrl_chk #(
   .NUM_CH (NUM_CH),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .done_irq  (done_irq),
   .bus_req   (bus_req),
   .bus_grant (bus_grant),
   .cpu_hold  (cpu_hold),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .mem_be    (mem_be)
);

// File: tb/irq_dma_ctrl_test.sv
module irq_dma_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_ch = '0;
   logic [1:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [3:0]  dma_req = '0;
   logic [3:0]  done_irq;
   logic        bus_req;
   logic        bus_grant = 1'b0;
   logic        cpu_hold;
   logic        mem_en;
   logic        mem_we;
   logic [23:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int acc_n = 0;
   int wr_n = 0;
   logic [23:0] wr_log [16];
   logic        grant_en = 1'b1;
   logic [31:0] mem [64];

   always #2 clk = ~clk;

   irq_dma_ctrl uut (
      .clk (clk), .rst_n (rst_n),
      .reg_we (reg_we), .reg_ch (reg_ch), .reg_sel (reg_sel), .reg_wdata (reg_wdata),
      .dma_req (dma_req), .done_irq (done_irq),
      .bus_req (bus_req), .bus_grant (bus_grant), .cpu_hold (cpu_hold),
      .mem_en (mem_en), .mem_we (mem_we), .mem_addr (mem_addr), .mem_be (mem_be),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
   );

   always @(posedge clk) begin
      bus_grant <= rst_n && grant_en && bus_req;
      if (mem_en) begin
         acc_n <= acc_n + 1;
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[7:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            if (wr_n < 16) wr_log[wr_n] <= mem_addr;
            wr_n <= wr_n + 1;
         end else begin
            mem_rdata <= mem[mem_addr[7:2]];
         end
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 50000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input int ch, input logic [1:0] fld, input logic [31:0] val);
      @(negedge clk);
      reg_we = 1'b1; reg_ch = 2'(ch); reg_sel = fld; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic setup(input int ch, input logic [31:0] src, input logic [31:0] dst,
                        input logic [31:0] cnt, input logic [1:0] unit, input logic [1:0] mode);
      wr_reg(ch, 2'd0, src);
      wr_reg(ch, 2'd1, dst);
      wr_reg(ch, 2'd3, {28'd0, mode, unit});
      wr_reg(ch, 2'd2, cnt);
   endtask

   task automatic fire(input logic [3:0] mask);
      @(negedge clk);
      dma_req = mask;
      @(negedge clk);
      dma_req = '0;
   endtask

   // waits for one unit to complete; returns done_irq sampled when hold drops
   task automatic unit_done(input string tag, output logic [3:0] done_seen);
      int t = 0;
      done_seen = '0;
      while (!cpu_hold && t < 40) begin @(negedge clk); t++; end
      while (cpu_hold && t < 80) begin @(negedge clk); t++; end
      if (t >= 80 || !cpu_hold && t >= 40 && done_irq == '0 && wr_n == 0) ;
      check({tag, " unit finished"}, 32'(t < 80), 32'd1);
      done_seen = done_irq;
   endtask

   task automatic t_reset;
      check("R10 hold low", 32'(cpu_hold), 0);
      check("R10 bus_req low", 32'(bus_req), 0);
      check("R10 mem_en low", 32'(mem_en), 0);
      check("R10 done low", 32'(done_irq), 0);
      fire(4'b1111);
      repeat (6) @(negedge clk);
      check("R10 R6 counts zero after reset, no hold", 32'(cpu_hold), 0);
      check("R10 no access", 32'(acc_n), 0);
   endtask

   task automatic t_byte_src_step;
      logic [3:0] d;
      mem[4] = 32'h44332211; mem[16] = '0;
      setup(0, 32'h10, 32'h41, 2, 2'd0, 2'd0);
      fire(4'b0001);
      unit_done("R2", d);
      check("R3 byte to lane 1", mem[16], 32'h00001100);
      check("R5 no done before last", 32'(d), 0);
      fire(4'b0001);
      unit_done("R2", d);
      check("R4 source stepped by 1, dst fixed", mem[16], 32'h00002200);
      check("R5 done on last unit", 32'(d), 32'h1);
      check("R2 two writes", 32'(wr_n), 2);
      check("R2 one read per write", 32'(acc_n), 4);
      fire(4'b0001);
      repeat (8) @(negedge clk);
      check("R6 exhausted channel no hold", 32'(cpu_hold), 0);
      check("R6 exhausted channel no access", 32'(acc_n), 4);
      check("R6 memory untouched", mem[16], 32'h00002200);
   endtask

   task automatic t_half_dst_step;
      logic [3:0] d;
      mem[8] = 32'hAABBCCDD; mem[20] = '0;
      setup(1, 32'h22, 32'h50, 2, 2'd1, 2'd1);
      fire(4'b0010);
      unit_done("R3", d);
      check("R3 upper half to low half", mem[20], 32'h0000AABB);
      fire(4'b0010);
      unit_done("R4", d);
      check("R4 dst stepped by 2, src fixed", mem[20], 32'hAABBAABB);
      check("R5 done ch1", 32'(d), 32'h2);
   endtask

   task automatic t_word_both;
      logic [3:0] d;
      mem[24] = 32'h01020304; mem[25] = 32'h05060708; mem[32] = '0; mem[33] = '0;
      setup(2, 32'h60, 32'h80, 2, 2'd2, 2'd2);
      fire(4'b0100);
      unit_done("R3", d);
      fire(4'b0100);
      unit_done("R4", d);
      check("R4 both step, first word", mem[32], 32'h01020304);
      check("R4 both step, second word", mem[33], 32'h05060708);
      check("R5 done ch2", 32'(d), 32'h4);
      check("R1 ch0 target not disturbed", mem[16], 32'h00002200);
   endtask

   task automatic t_word_fixed;
      logic [3:0] d;
      mem[12] = 32'hCAFE0001; mem[36] = '0; mem[37] = '0;
      setup(3, 32'h30, 32'h90, 3, 2'd2, 2'd3);
      fire(4'b1000);
      unit_done("R4", d);
      check("R4 fixed first copy", mem[36], 32'hCAFE0001);
      mem[12] = 32'hCAFE0002;
      fire(4'b1000);
      unit_done("R4", d);
      check("R4 fixed both addresses", mem[36], 32'hCAFE0002);
      check("R4 neighbour untouched", mem[37], 32'h0);
      check("R5 count 3 not done after 2", 32'(d), 0);
   endtask

   task automatic t_priority;
      logic [3:0] d1;
      logic [3:0] d2;
      int base;
      mem[44] = '0; mem[48] = '0;
      setup(1, 32'h60, 32'hB0, 1, 2'd2, 2'd2);
      setup(3, 32'h64, 32'hC0, 1, 2'd2, 2'd2);
      base = wr_n;
      fire(4'b1010);
      unit_done("R7", d1);
      unit_done("R7", d2);
      check("R7 lower channel written first", 32'(wr_log[base]), 32'hB0);
      check("R7 higher channel served after", 32'(wr_log[base+1]), 32'hC0);
      check("R7 first done ch1", 32'(d1), 32'h2);
      check("R7 second done ch3", 32'(d2), 32'h8);
      check("R1 ch1 data", mem[44], 32'h01020304);
      check("R1 ch3 data", mem[48], 32'h05060708);
   endtask

   task automatic t_grant_wait;
      logic [3:0] d;
      int a0;
      mem[40] = '0;
      setup(0, 32'h60, 32'hA0, 1, 2'd2, 2'd3);
      grant_en = 1'b0;
      a0 = acc_n;
      fire(4'b0001);
      repeat (10) @(negedge clk);
      check("R9 hold while waiting for grant", 32'(cpu_hold), 1);
      check("R8 bus requested", 32'(bus_req), 1);
      check("R8 no access without grant", 32'(acc_n - a0), 0);
      grant_en = 1'b1;
      unit_done("R8", d);
      check("R8 transfer after grant", mem[40], 32'h01020304);
      check("R5 done ch0", 32'(d), 32'h1);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_byte_src_step();
      t_half_dst_step();
      t_word_both();
      t_word_fixed();
      t_priority();
      t_grant_wait();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule